// File: doc/BRIEF.md
# DRAM Burst Cycle Sequencer with Programmable Wait States

This block drives the row strobe (`rasN`), the column strobe (`casN`) and the row/column address-multiplexer select for four-beat CPU burst accesses to DRAM. A request carries a row, a starting column and a flag that says whether the caller expects the row to be the one already open. The sequencer precharges and opens a new row when it must. It then runs four CAS beats over linearly increasing column addresses, and it reports completion with a single-cycle `done` pulse.

Two row-strobe policies are selected by the `openPolicy` pin. With the page-open policy, the row stays active after a burst, so a later hit to the same page goes straight to the column phase. With the always-precharge policy, the row is closed at the end of every burst. A small configuration register holds two independent wait-state enables. One adds a clock of address setup before the row strobe falls. The other adds a clock of column-address setup before the first CAS of a burst.

Top module: `dram_burst_seq`

## Requirements
- R1: The timing register sits at configuration offset 58h and resets to 00h. Bit 1 enables the RAS wait and bit 0 enables the CAS wait. Bits 7:2 always read 0 and writes to them are ignored. A read at any other offset returns 00h, and a write at any other offset changes nothing.
- R2: `reqReady` is high exactly while the sequencer is idle. A request is accepted on a rising edge with `reqValid` and `reqReady` both high. A `reqValid` raised while busy is ignored: it does not change the burst in flight or the captured row.
- R3: Cycle 1 is the clock period that follows the accepting edge. An access that needs a new row holds `rasN` high for cycles 1 and 2 (precharge). It drives the row on `maOut` with `maSel`=0 (0 = row, 1 = column) and pulls `rasN` low in cycle 3 when the RAS wait is off.
- R4: When the RAS wait is enabled, `rasN` falls one cycle later (cycle 4). This applies to every access under the always-precharge policy, and under the page-open policy to every access that is not a page hit.
- R5: Under the page-open policy, a request flagged as a page hit whose row was left open by the previous page-open burst skips precharge. `rasN` stays low throughout, the RAS wait has no effect, and the first CAS falls in cycle 1, or cycle 2 with the CAS wait.
- R6: `maSel` switches to column in the cycle after `rasN` falls. With the CAS wait enabled, one extra cycle with the first column on `maOut` and `casN` high precedes the first CAS. With the CAS wait off, that cycle is itself the first CAS.
- R7: A burst has four CAS pulses, each one clock low and one clock high, with no added gap when the CAS wait is on. Beat b presents column (start + b) mod 2^COL_W on `maOut`. CAS is only low while `rasN` is low.
- R8: `done` is high for one cycle, namely the cycle in which `casN` rises after the fourth beat. The sequencer is idle in the next cycle.
- R9: After a burst, `rasN` stays low while idle under the page-open policy and returns high under the always-precharge policy. After reset, `rasN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgAddr | input | 8 | Configuration register offset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data for `cfgAddr` |
| openPolicy | input | 1 | 1 = keep row open after a burst, 0 = precharge after every burst |
| reqValid | input | 1 | Burst request |
| reqPageHit | input | 1 | Requester expects the currently open row |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Starting column address |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | Last CAS deasserted |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| maSel | output | 1 | Address mux select, 0 = row, 1 = column |
| maOut | output | max(ROW_W,COL_W) | Multiplexed DRAM address |

## Verification
The sweep crosses both policies with all four wait-state settings and with page-hit and page-miss requests. It also uses starting columns that include one wrapping past the top of the column space. Every output is compared each cycle against a schedule the bench computes from the timing rules. Hit requests made under the always-precharge policy, or made before any row is open, must behave exactly like misses. This separates a real page hit from the flag alone. Comparing the two wait enables tells apart a delay before RAS, a delay before the first CAS, and a wrongly stretched CAS spacing. A request raised in the middle of a burst shows whether busy-time requests leak into the captured row or the timing.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RWAIT,
    ST_RAS,
    ST_CWAIT,
    ST_CASLO,
    ST_CASHI
  } seqState_t;

  // strobes from control to address datapath
  typedef struct packed {
    logic capture;   // load row / start column, clear beat offset
    logic beatAdv;   // step to the next column
    logic colSel;    // present column instead of row
  } seqStrobe_t;

endpackage

// File: rtl/dram_seq_cfg.sv
module dram_seq_cfg #(
  parameter logic [7:0] CFG_OFFSET = 8'h58
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cfgAddr,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgRdData,
  output logic       rasWait,
  output logic       casWait
);

  logic [1:0] waitBits;
  logic       hitAddr;
  logic       unusedHi;

  assign hitAddr  = (cfgAddr == CFG_OFFSET);
  assign unusedHi = ^cfgWrData[7:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  waitBits <= 2'b00;
    else if (cfgWrEn && hitAddr) waitBits <= cfgWrData[1:0];
  end

  assign cfgRdData = hitAddr ? {6'b0, waitBits} : 8'h00;
  assign rasWait   = waitBits[1];
  assign casWait   = waitBits[0];

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && hitAddr) |=> (rasWait == $past(cfgWrData[1]) && casWait == $past(cfgWrData[0]))); // R1
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && hitAddr) |=> $stable({rasWait, casWait})); // R1

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int PRE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqPageHit,
  input  logic       openPolicy,
  input  logic       rasWait,
  input  logic       casWait,
  input  logic       lastBeat,
  output logic       reqReady,
  output logic       done,
  output logic       rasN,
  output logic       casN,
  output seqStrobe_t strobe
);

  localparam int PRE_W = (PRE_CLKS > 1) ? $clog2(PRE_CLKS) : 1;

  seqState_t  state, nextState;
  logic [PRE_W-1:0] preCnt;
  logic       waitRasQ, waitCasQ, keepOpenQ, rasOpen;
  logic       accept, pageHitNow, preDone;

  assign accept     = reqValid && (state == ST_IDLE);
  assign pageHitNow = openPolicy && rasOpen && reqPageHit;
  assign preDone    = (preCnt == PRE_W'(PRE_CLKS - 1));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (accept) nextState = pageHitNow ? (casWait ? ST_CWAIT : ST_CASLO) : ST_PRE;
      ST_PRE:   if (preDone) nextState = waitRasQ ? ST_RWAIT : ST_RAS;
      ST_RWAIT: nextState = ST_RAS;
      ST_RAS:   nextState = waitCasQ ? ST_CWAIT : ST_CASLO;
      ST_CWAIT: nextState = ST_CASLO;
      ST_CASLO: nextState = ST_CASHI;
      ST_CASHI: nextState = lastBeat ? ST_IDLE : ST_CASLO;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      preCnt    <= '0;
      waitRasQ  <= 1'b0;
      waitCasQ  <= 1'b0;
      keepOpenQ <= 1'b0;
      rasOpen   <= 1'b0;
    end else begin
      state  <= nextState;
      preCnt <= (state == ST_PRE) ? preCnt + PRE_W'(1) : '0;
      if (accept) begin
        waitRasQ  <= rasWait;
        waitCasQ  <= casWait;
        keepOpenQ <= openPolicy;
        if (!pageHitNow) rasOpen <= 1'b0;
      end
      if (state == ST_RAS) rasOpen <= 1'b1;
      if (state == ST_CASHI && lastBeat) rasOpen <= keepOpenQ;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_CASHI) && lastBeat;
  assign casN     = (state != ST_CASLO);
  assign rasN     = !((state inside {ST_RAS, ST_CWAIT, ST_CASLO, ST_CASHI}) ||
                      (state == ST_IDLE && rasOpen));

  assign strobe.capture = accept;
  assign strobe.beatAdv = (state == ST_CASHI) && !lastBeat;
  assign strobe.colSel  = state inside {ST_CWAIT, ST_CASLO, ST_CASHI};

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN); // R7
  AST_CAS_ONE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !casN |=> casN); // R7
  AST_COL_AT_CAS: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> strobe.colSel); // R6
  AST_ROW_AT_RAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !strobe.colSel); // R3
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2

endmodule

// File: rtl/dram_seq_dp.sv
module dram_seq_dp
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int BEATS = 4,
  parameter int MA_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  output logic             lastBeat,
  output logic [MA_W-1:0]  maOut
);

  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colBaseQ, colAddr;
  logic [BEAT_W-1:0] beatOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ     <= '0;
      colBaseQ <= '0;
      beatOff  <= '0;
    end else if (strobe.capture) begin
      rowQ     <= reqRow;
      colBaseQ <= reqCol;
      beatOff  <= '0;
    end else if (strobe.beatAdv) begin
      beatOff  <= beatOff + BEAT_W'(1);
    end
  end

  assign colAddr  = colBaseQ + COL_W'(beatOff);
  assign lastBeat = (beatOff == BEAT_W'(BEATS - 1));
  assign maOut    = strobe.colSel ? MA_W'(colAddr) : MA_W'(rowQ);

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.beatAdv && !strobe.capture) |=> (beatOff == $past(beatOff) + BEAT_W'(1))); // R7

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
  import dram_seq_pkg::*;
#(
  parameter int         ROW_W      = 12,
  parameter int         COL_W      = 10,
  parameter int         BEATS      = 4,
  parameter int         PRE_CLKS   = 2,
  parameter logic [7:0] CFG_OFFSET = 8'h58
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic [7:0]                                 cfgAddr,
  input  logic                                       cfgWrEn,
  input  logic [7:0]                                 cfgWrData,
  output logic [7:0]                                 cfgRdData,
  input  logic                                       openPolicy,
  input  logic                                       reqValid,
  input  logic                                       reqPageHit,
  input  logic [ROW_W-1:0]                           reqRow,
  input  logic [COL_W-1:0]                           reqCol,
  output logic                                       reqReady,
  output logic                                       done,
  output logic                                       rasN,
  output logic                                       casN,
  output logic                                       maSel,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] maOut
);

  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic       rasWait, casWait, lastBeat;
  seqStrobe_t strobe;

  dram_seq_cfg #(.CFG_OFFSET(CFG_OFFSET)) uCfg (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .rasWait(rasWait), .casWait(casWait)
  );

  dram_seq_ctrl #(.PRE_CLKS(PRE_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPageHit(reqPageHit),
    .openPolicy(openPolicy), .rasWait(rasWait), .casWait(casWait),
    .lastBeat(lastBeat), .reqReady(reqReady), .done(done),
    .rasN(rasN), .casN(casN), .strobe(strobe)
  );

  dram_seq_dp #(.ROW_W(ROW_W), .COL_W(COL_W), .BEATS(BEATS), .MA_W(MA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqRow(reqRow), .reqCol(reqCol),
    .lastBeat(lastBeat), .maOut(maOut)
  );

  assign maSel = strobe.colSel;

endmodule

// File: tb/tb_dram_burst_seq.sv
module tb_dram_burst_seq;

  localparam int ROW_W = 12;
  localparam int COL_W = 10;
  localparam int MA_W  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgAddr = 8'h00, cfgWrData = 8'h00, cfgRdData;
  logic cfgWrEn = 1'b0, openPolicy = 1'b0, reqValid = 1'b0, reqPageHit = 1'b0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic reqReady, done, rasN, casN, maSel;
  logic [MA_W-1:0] maOut;

  int vecs = 0;
  int errs = 0;
  bit benchOpen = 1'b0;

  always #10 clk = ~clk;

  dram_burst_seq dut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .openPolicy(openPolicy),
    .reqValid(reqValid), .reqPageHit(reqPageHit), .reqRow(reqRow), .reqCol(reqCol),
    .reqReady(reqReady), .done(done), .rasN(rasN), .casN(casN),
    .maSel(maSel), .maOut(maOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgCheck(input logic [7:0] a, input logic [7:0] exp);
    cfgAddr = a;
    #1;
    chk(cfgRdData == exp, "R1", "register read", cfgRdData, exp);
  endtask

  // one burst; starts at a negedge, ends at a negedge with the block idle
  task automatic runAccess(input bit pol, input bit hit, input bit rw, input bit cw,
                           input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                           input bit poke);
    bit isHit;
    int tRas, tCas0, tDone;
    isHit = pol && benchOpen && hit;
    tCas0 = isHit ? 1 + int'(cw) : 4 + int'(rw) + int'(cw);
    tRas  = isHit ? 0 : 3 + int'(rw);
    tDone = tCas0 + 7;
    openPolicy = pol; reqPageHit = hit; reqRow = row; reqCol = col; reqValid = 1'b1;
    for (int c = 1; c <= tDone + 2; c++) begin
      int beat;
      bit expCas, expRas, expSel;
      int expMa;
      string rasTag, casTag;
      @(negedge clk);
      beat   = (c < tCas0) ? 0 : (c - tCas0) / 2;
      expCas = !((c >= tCas0) && (c < tCas0 + 8) && (((c - tCas0) % 2) == 0));
      if (c > tDone)  expRas = !pol;
      else if (isHit) expRas = 1'b0;
      else            expRas = (c < tRas);
      expSel = (c >= tCas0 - int'(cw)) && (c <= tDone);
      expMa  = expSel ? ((int'(col) + beat) % (1 << COL_W)) : int'(row);
      rasTag = (c > tDone) ? "R9" : (isHit ? "R5" : (rw ? "R4" : "R3"));
      casTag = isHit ? "R5" : (cw ? "R6" : "R7");
      chk(rasN == expRas, rasTag, "rasN", rasN, expRas);
      chk(casN == expCas, casTag, "casN", casN, expCas);
      chk(maSel == expSel, "R6", "maSel", maSel, expSel);
      chk(int'(maOut) == expMa, expSel ? "R7" : "R3", "maOut", maOut, expMa);
      chk(done == (c == tDone), "R8", "done", done, (c == tDone));
      chk(reqReady == (c > tDone), "R2", "reqReady", reqReady, (c > tDone));
      if (c == 1) reqValid = 1'b0;
      if (poke && c == 4) begin
        reqValid = 1'b1; reqRow = ~row; reqCol = ~col; reqPageHit = ~hit;
      end
      if (poke && c == 5) reqValid = 1'b0;
    end
    benchOpen = pol;
  endtask

  initial begin
    logic [ROW_W-1:0] rows [3];
    logic [COL_W-1:0] cols [3];
    rows[0] = 12'h000; rows[1] = 12'hA5C; rows[2] = 12'hFFF;
    cols[0] = 10'h000; cols[1] = 10'h3FE; cols[2] = 10'h155;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk(reqReady == 1'b1, "R2", "reset reqReady", reqReady, 1);
    chk(rasN == 1'b1, "R9", "reset rasN", rasN, 1);
    chk(casN == 1'b1, "R7", "reset casN", casN, 1);
    chk(done == 1'b0, "R8", "reset done", done, 0);
    cfgCheck(8'h58, 8'h00);
    // register map
    cfgWrite(8'h58, 8'hFF);
    cfgCheck(8'h58, 8'h03);
    cfgWrite(8'h57, 8'h00);
    cfgCheck(8'h58, 8'h03);
    cfgCheck(8'h57, 8'h00);
    cfgWrite(8'h59, 8'hFE);
    cfgCheck(8'h59, 8'h00);
    cfgCheck(8'h58, 8'h03);
    // sweep: policy x wait settings x hit flag x column starts
    for (int pol = 0; pol < 2; pol++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        cfgWrite(8'h58, 8'hFC | 8'(cfg));
        cfgCheck(8'h58, 8'(cfg));
        for (int hit = 0; hit < 2; hit++) begin
          for (int k = 0; k < 3; k++) begin
            runAccess(pol[0], hit[0], cfg[1], cfg[0], rows[k], cols[k], k == 1);
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule